// File: doc/BRIEF.md
# Link Power Status Activity Monitor

This block watches a single link power status line coming from a link-layer controller and decides, from how long that line stays low, whether the link is powered. The line may be tied steadily high, or it may be a pulse train, for example when it crosses an isolation barrier. Short low gaps in such a pulse train never count against the link. The line is sampled by a free-running clock and passed through a synchronizer. Only a low time that runs past a first cycle threshold moves the link into a low-power reset condition. A low time that runs past a second, longer threshold moves it into a low-power disabled condition.

The block sits between the PHY core and the link interface pins. In either low-power condition it forces the control and data lines towards the link to zero and masks the link's request input. The PHY clock output stays enabled in the reset condition and is switched off only in the disabled condition. The block also produces the link-active bit that the self-ID packet carries. That bit is the monitor's verdict combined with a software-controlled link-enable bit. A high level on the line must persist for a programmable number of consecutive samples before it counts as high. A qualified high returns the link straight to the active condition from either low-power condition.

With the default 49.152 MHz sample clock, the 128-cycle threshold corresponds to roughly 2.6 µs and the 1278-cycle threshold to roughly 26 µs.

Top module: `linkPowerMonitor`

## Requirements
- R1: After reset the monitor is in the active condition (`linkState` = 0). `pclkEn` is 1, the interface inputs pass straight through to the outputs, and the low-time count is cleared.
- R2: The status line passes through a two-stage synchronizer. A low-time counter then adds one per sample while the line is not qualified high, and it saturates at `DISABLE_CYCLES`.
- R3: Once the low-time count reaches `RESET_CYCLES`, the reset condition (`linkState` = 1) begins on the next clock edge. That is `RESET_CYCLES`+3 edges after the input falls. A low time too short to reach the count leaves the link active.
- R4: In the reset condition, `ctlOut`, `dataOut` and `lreqOut` are all 0 whatever their inputs are, and `pclkEn` stays 1.
- R5: Once the low-time count reaches `DISABLE_CYCLES`, the disabled condition (`linkState` = 2) begins on the next edge. The outputs stay held at 0 and `pclkEn` becomes 0. The disabled condition is only ever entered from the reset condition.
- R6: A pulsed input whose low stretches stay below the reset threshold keeps the link continuously active.
- R7: A high is qualified only after `HIGH_SAMPLES` consecutive synchronized high samples. A shorter high neither clears the low-time count nor delays entry into the reset condition. A qualified high clears the count on the next edge.
- R8: From either low-power condition, the link returns to active on the edge after the first qualified high sample. That is 2+`HIGH_SAMPLES` edges after the input rises.
- R9: `linkActive` is 1 only when the link is in the active condition and `lctrlBit` is 1. Otherwise it is 0.
- R10: `linkState` encodes the condition as 0 = active, 1 = reset, 2 = disabled. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset |
| lpsIn | input | 1 | Asynchronous link power status line (steady or pulsed) |
| lctrlBit | input | 1 | Software link-enable bit for the self-ID report |
| lreqIn | input | 1 | Request line from the link |
| ctlIn | input | CTL_W | Control lines from the PHY core |
| dataIn | input | DATA_W | Data lines from the PHY core |
| lreqOut | output | 1 | Request towards the PHY core, masked when low-power |
| ctlOut | output | CTL_W | Control lines towards the link, held 0 when low-power |
| dataOut | output | DATA_W | Data lines towards the link, held 0 when low-power |
| pclkEn | output | 1 | PHY clock output enable, 0 only when disabled |
| linkActive | output | 1 | Link-active bit for the self-ID packet |
| linkState | output | 2 | Condition code: 0 active, 1 reset, 2 disabled |

## Verification
The monitor is driven with a long unbroken low, which separates the timing of the reset threshold from that of the disabled threshold. Low stretches of exactly one sample below and one sample at the reset boundary pin down the count comparison. A pulse train with short lows shows that oscillation counts as activity. A single-sample high glitch inside a low stretch shows that an unqualified high neither clears the count nor delays the reset condition. Returns from both low-power conditions, and toggling the link-enable bit in the active and reset conditions, separate the monitor's verdict from the self-ID report.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LNK_ACTIVE   = 2'd0,
    LNK_RESET    = 2'd1,
    LNK_DISABLED = 2'd2
  } linkState_e;

  // datapath -> control: what the low-time timer currently observes
  typedef struct packed {
    logic qualHigh;     // synchronized line is a qualified high this cycle
    logic pastReset;    // low-time count has reached the reset threshold
    logic pastDisable;  // low-time count has reached the disabled threshold
  } lowFlags_t;

  // control -> datapath: gating strobes
  typedef struct packed {
    logic holdIo;       // force ctl/data low, mask request
    logic stopClk;      // clear the PHY clock enable
    logic linkUp;       // monitor verdict for the self-ID report
  } gateStrobe_t;

endpackage

// File: rtl/lpmSync.sv
module lpmSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RESET_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/lpmDatapath.sv
module lpmDatapath
  import lpm_pkg::*;
#(
  parameter int RESET_CYCLES   = 128,
  parameter int DISABLE_CYCLES = 1278,
  parameter int HIGH_SAMPLES   = 1,
  parameter int SYNC_STAGES    = 2,
  parameter int CTL_W          = 2,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lpsIn,
  input  gateStrobe_t       strobe,
  input  logic              lctrlBit,
  input  logic              lreqIn,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output lowFlags_t         flags,
  output logic              lreqOut,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              pclkEn,
  output logic              linkActive
);

  localparam int CNT_W  = $clog2(DISABLE_CYCLES + 1);
  localparam int RUN_W  = $clog2(HIGH_SAMPLES + 1);
  localparam int RUN_TOP = HIGH_SAMPLES - 1;

  logic             lpsSync;
  logic [RUN_W-1:0] highRun;
  logic [CNT_W-1:0] lowCount;
  logic             qualHigh;
  logic             cntAtTop;

  lpmSync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(lpsIn),
    .syncOut(lpsSync)
  );

  // consecutive synchronized high samples, saturating at HIGH_SAMPLES-1
  always_ff @(posedge clk) begin
    if (rst) begin
      highRun <= RUN_W'(RUN_TOP);
    end else if (!lpsSync) begin
      highRun <= '0;
    end else if (highRun < RUN_W'(RUN_TOP)) begin
      highRun <= highRun + 1'b1;
    end
  end

  assign qualHigh = lpsSync && (highRun >= RUN_W'(RUN_TOP));
  assign cntAtTop = (lowCount >= CNT_W'(DISABLE_CYCLES));

  // low-time counter: anything not a qualified high counts as low
  always_ff @(posedge clk) begin
    if (rst) begin
      lowCount <= '0;
    end else if (qualHigh) begin
      lowCount <= '0;
    end else if (!cntAtTop) begin
      lowCount <= lowCount + 1'b1;
    end
  end

  always_comb begin
    flags.qualHigh    = qualHigh;
    flags.pastReset   = (lowCount >= CNT_W'(RESET_CYCLES));
    flags.pastDisable = cntAtTop;
  end

  // interface gating
  always_comb begin
    if (strobe.holdIo) begin
      ctlOut  = '0;
      dataOut = '0;
      lreqOut = 1'b0;
    end else begin
      ctlOut  = ctlIn;
      dataOut = dataIn;
      lreqOut = lreqIn;
    end
    pclkEn     = !strobe.stopClk;
    linkActive = strobe.linkUp && lctrlBit;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    lowCount <= CNT_W'(DISABLE_CYCLES)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!qualHigh && !cntAtTop) |=> (lowCount == CNT_W'($past(lowCount) + 1'b1))); // R2

  AST_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    qualHigh |=> (lowCount == '0)); // R7

endmodule

// File: rtl/lpmControl.sv
module lpmControl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lowFlags_t   flags,
  output gateStrobe_t strobe,
  output logic [1:0]  stateCode
);

  linkState_e state;
  linkState_e stateNext;

  always_comb begin
    stateNext = state;
    if (flags.qualHigh) begin
      stateNext = LNK_ACTIVE;
    end else if (flags.pastDisable) begin
      stateNext = LNK_DISABLED;
    end else if (flags.pastReset) begin
      stateNext = LNK_RESET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LNK_ACTIVE;
    else     state <= stateNext;
  end

  always_comb begin
    strobe.holdIo  = (state != LNK_ACTIVE);
    strobe.stopClk = (state == LNK_DISABLED);
    strobe.linkUp  = (state == LNK_ACTIVE);
  end

  assign stateCode = state;

  AST_NO_SKIP_RESET: assert property (@(posedge clk) disable iff (rst)
    (state == LNK_DISABLED) |-> ($past(state) != LNK_ACTIVE)); // R5

  AST_WAKE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    flags.qualHigh |=> (state == LNK_ACTIVE)); // R8

  AST_STATE_CODE: assert property (@(posedge clk) disable iff (rst)
    stateCode != 2'd3); // R10

  AST_STAY_LOW: assert property (@(posedge clk) disable iff (rst)
    ((state != LNK_ACTIVE) && !flags.qualHigh) |=> (state != LNK_ACTIVE)); // R3

endmodule

// File: rtl/linkPowerMonitor.sv
module linkPowerMonitor
  import lpm_pkg::*;
#(
  parameter int RESET_CYCLES   = 128,
  parameter int DISABLE_CYCLES = 1278,
  parameter int HIGH_SAMPLES   = 1,
  parameter int CTL_W          = 2,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lpsIn,
  input  logic              lctrlBit,
  input  logic              lreqIn,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              lreqOut,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              pclkEn,
  output logic              linkActive,
  output logic [1:0]        linkState
);

  localparam int SYNC_STAGES = 2;

  lowFlags_t   flags;
  gateStrobe_t strobe;

  lpmDatapath #(
    .RESET_CYCLES  (RESET_CYCLES),
    .DISABLE_CYCLES(DISABLE_CYCLES),
    .HIGH_SAMPLES  (HIGH_SAMPLES),
    .SYNC_STAGES   (SYNC_STAGES),
    .CTL_W         (CTL_W),
    .DATA_W        (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .lpsIn     (lpsIn),
    .strobe    (strobe),
    .lctrlBit  (lctrlBit),
    .lreqIn    (lreqIn),
    .ctlIn     (ctlIn),
    .dataIn    (dataIn),
    .flags     (flags),
    .lreqOut   (lreqOut),
    .ctlOut    (ctlOut),
    .dataOut   (dataOut),
    .pclkEn    (pclkEn),
    .linkActive(linkActive)
  );

  lpmControl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .flags    (flags),
    .strobe   (strobe),
    .stateCode(linkState)
  );

endmodule

// File: tb/sim_linkPowerMonitor.sv
module sim_linkPowerMonitor;

  localparam int RST_TH  = 8;
  localparam int DIS_TH  = 20;
  localparam int HI_SMP  = 2;
  localparam int CW      = 2;
  localparam int DW      = 8;
  localparam logic [1:0] S_ACT = 2'd0;
  localparam logic [1:0] S_RST = 2'd1;
  localparam logic [1:0] S_DIS = 2'd2;

  typedef struct {
    int         cyc;
    logic [1:0] st;
    logic       lc;
    string      req;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          lpsIn;
  logic          lctrlBit;
  logic          lreqIn;
  logic [CW-1:0] ctlIn;
  logic [DW-1:0] dataIn;
  logic          lreqOut;
  logic [CW-1:0] ctlOut;
  logic [DW-1:0] dataOut;
  logic          pclkEn;
  logic          linkActive;
  logic [1:0]    linkState;

  int       cycleCnt = 0;
  int       nChecks  = 0;
  int       nFails   = 0;
  bit       finished = 1'b0;
  expItem_t sbQueue[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  linkPowerMonitor #(
    .RESET_CYCLES  (RST_TH),
    .DISABLE_CYCLES(DIS_TH),
    .HIGH_SAMPLES  (HI_SMP),
    .CTL_W         (CW),
    .DATA_W        (DW)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .lpsIn     (lpsIn),
    .lctrlBit  (lctrlBit),
    .lreqIn    (lreqIn),
    .ctlIn     (ctlIn),
    .dataIn    (dataIn),
    .lreqOut   (lreqOut),
    .ctlOut    (ctlOut),
    .dataOut   (dataOut),
    .pclkEn    (pclkEn),
    .linkActive(linkActive),
    .linkState (linkState)
  );

  task automatic pushExp(input int cyc, input logic [1:0] st, input string req);
    expItem_t it;
    it.cyc = cyc;
    it.st  = st;
    it.lc  = lctrlBit;
    it.req = req;
    sbQueue.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare at the falling edge, after the rising edge settled
  always @(negedge clk) begin
    while (sbQueue.size() > 0 && sbQueue[0].cyc <= cycleCnt) begin
      expItem_t it;
      logic [CW-1:0] eCtl;
      logic [DW-1:0] eDat;
      logic eReq, ePclk, eLink;
      bit hold;
      it    = sbQueue.pop_front();
      hold  = (it.st != S_ACT);
      eCtl  = hold ? '0 : ctlIn;
      eDat  = hold ? '0 : dataIn;
      eReq  = hold ? 1'b0 : lreqIn;
      ePclk = (it.st != S_DIS);
      eLink = (it.st == S_ACT) && it.lc;
      nChecks++;
      if (it.cyc != cycleCnt) begin
        nFails++;
        $display("FAIL %s stale item: actual cycle=%0d expected cycle=%0d", it.req, cycleCnt, it.cyc);
      end else if (linkState !== it.st || ctlOut !== eCtl || dataOut !== eDat ||
                   lreqOut !== eReq || pclkEn !== ePclk || linkActive !== eLink) begin
        nFails++;
        $display("FAIL %s cycle %0d: actual st=%0d ctl=%h dat=%h req=%b pclk=%b link=%b expected st=%0d ctl=%h dat=%h req=%b pclk=%b link=%b",
                 it.req, cycleCnt, linkState, ctlOut, dataOut, lreqOut, pclkEn, linkActive,
                 it.st, eCtl, eDat, eReq, ePclk, eLink);
      end
    end
  end

  initial begin
    int base;
    rst = 1'b1; lpsIn = 1'b1; lctrlBit = 1'b1;
    lreqIn = 1'b1; ctlIn = 2'b11; dataIn = 8'hA5;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    base = cycleCnt;
    pushExp(base + 1, S_ACT, "R1");   // reset state: active, pass-through
    pushExp(base + 3, S_ACT, "R1");
    idle(6);

    // long low: reset at +11, disabled at +23
    base = cycleCnt; lpsIn = 1'b0;
    pushExp(base + 10, S_ACT, "R3");
    pushExp(base + 11, S_RST, "R3");
    pushExp(base + 15, S_RST, "R4");  // outputs held, clock on
    pushExp(base + 22, S_RST, "R5");
    pushExp(base + 23, S_DIS, "R5");
    pushExp(base + 25, S_DIS, "R5");
    idle(26);

    // rise from disabled: active at +(2+HI_SMP)
    base = cycleCnt; lpsIn = 1'b1;
    pushExp(base + 3, S_DIS, "R8");
    pushExp(base + 4, S_ACT, "R8");
    idle(8);

    // reset again, new data pattern, then rise from reset
    ctlIn = 2'b01; dataIn = 8'h3C; lreqIn = 1'b1;
    base = cycleCnt; lpsIn = 1'b0;
    pushExp(base + 11, S_RST, "R4");
    idle(14);
    base = cycleCnt; lpsIn = 1'b1;
    pushExp(base + 3, S_RST, "R8");
    pushExp(base + 4, S_ACT, "R8");
    idle(8);

    // pulsed input: lows of 5, highs of 3
    for (int p = 0; p < 10; p++) begin
      base = cycleCnt; lpsIn = 1'b0;
      for (int k = 1; k <= 5; k++) pushExp(base + k, S_ACT, "R6");
      idle(5);
      base = cycleCnt; lpsIn = 1'b1;
      for (int k = 1; k <= 3; k++) pushExp(base + k, S_ACT, "R6");
      idle(3);
    end
    idle(6);

    // one-cycle glitch inside a low stretch does not restart the count
    base = cycleCnt; lpsIn = 1'b0;
    pushExp(base + 10, S_ACT, "R7");
    pushExp(base + 11, S_RST, "R7");
    idle(4);
    lpsIn = 1'b1;
    idle(1);
    lpsIn = 1'b0;
    idle(10);
    base = cycleCnt; lpsIn = 1'b1;
    pushExp(base + 4, S_ACT, "R7");
    idle(8);

    // boundary: low for 7 stays active, low for 8 gives one reset cycle
    base = cycleCnt; lpsIn = 1'b0;
    for (int k = 1; k <= 14; k++) pushExp(base + k, S_ACT, "R3");
    idle(7);
    lpsIn = 1'b1;
    idle(10);
    base = cycleCnt; lpsIn = 1'b0;
    pushExp(base + 10, S_ACT, "R3");
    pushExp(base + 11, S_RST, "R3");
    pushExp(base + 12, S_ACT, "R3");
    idle(8);
    lpsIn = 1'b1;
    idle(8);

    // self-ID report gated by the software bit
    lctrlBit = 1'b0;
    base = cycleCnt;
    pushExp(base + 1, S_ACT, "R9");
    idle(3);
    base = cycleCnt; lpsIn = 1'b0;
    pushExp(base + 11, S_RST, "R9");
    idle(13);
    lctrlBit = 1'b1;
    base = cycleCnt;
    pushExp(base + 1, S_RST, "R9");
    idle(2);
    base = cycleCnt; lpsIn = 1'b1;
    pushExp(base + 4, S_ACT, "R9");
    pushExp(base + 5, S_ACT, "R10");
    idle(8);

    while (sbQueue.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog (R1..all): actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule